// File: doc/BRIEF.md
# Banked 24-bit Effective Address Generator

This unit turns an addressing-mode code and the relevant processor state into a 24-bit bus address for a processor with 16-bit registers and a 256-bank memory map. The state it uses is the direct-page base, the stack pointer, the data and program bank bytes, the program counter and an index value. The operand comes in three forms: a 16-bit word, an 8-bit offset or a 24-bit long address. The mode code decides which of these feed the sum and where the bank byte comes from.

Some modes pin the result to bank 0: direct page, stack-relative and vector. Absolute data uses the data bank. Instruction fetch and PC-relative long use the program bank. A long operand bypasses banking altogether. Indexed data may carry into the following bank, and a flag reports when that happens. The PC-relative sum stays inside the current program bank. A mode code with no meaning yields address zero and raises an error flag.

A request is presented with `in_valid`. The result is registered and appears one clock later, together with `out_valid`.

Top module: `ea_addr_gen`

## Requirements
- R1: Mode code 0 (direct page) gives bank 0x00 and low half (dp_base + zero-extended offset8) mod 65536. The low half never carries into bank 1, and dp_base needs no alignment.
- R2: Mode code 1 (stack-relative) gives bank 0x00 and low half (stack_ptr + zero-extended offset8) mod 65536.
- R3: Mode code 2 (absolute) gives {data_bank, operand16}.
- R4: Mode code 5 (instruction fetch) gives {prog_bank, prog_ctr}.
- R5: Mode code 4 (long) passes long_operand through unchanged as the 24-bit address.
- R6: Mode code 3 (absolute indexed) gives ({data_bank, operand16} + index) mod 2^24, so a carry out of the low 16 bits increments the bank byte, and bank 0xFF wraps to 0x00.
- R7: Mode code 6 (PC-relative long) gives {prog_bank, (prog_ctr + operand16) mod 65536}. Here prog_ctr is the address of the next instruction and operand16 is a signed two's-complement offset.
- R8: Mode code 7 (vector) gives {0x00, operand16}.
- R9: bank_carry is 1 exactly when the mode is 3 and operand16 + index exceeds 0xFFFF. For every other mode it is 0.
- R10: Mode codes 8 to 15 give address 0x000000 with bad_mode set to 1. Valid codes give bad_mode 0.
- R11: The result of a request appears one clock after in_valid, with out_valid high. While out_valid is low, bank_carry and bad_mode are 0. Synchronous reset clears out_valid, the address and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code |
| operand16 | input | 16 | 16-bit operand or signed PC offset |
| offset8 | input | 8 | 8-bit direct-page or stack offset |
| long_operand | input | 24 | Full 24-bit operand for long mode |
| index | input | 16 | Index register value |
| dp_base | input | 16 | Direct-page base |
| stack_ptr | input | 16 | Stack pointer |
| data_bank | input | 8 | Data bank byte |
| prog_bank | input | 8 | Program bank byte |
| prog_ctr | input | 16 | Program counter (next instruction) |
| out_valid | output | 1 | Result valid |
| addr | output | 24 | Effective address |
| bank_carry | output | 1 | Indexed sum crossed into the next bank |
| bad_mode | output | 1 | Unsupported mode code |

## Verification
The per-cycle checks cover the following:
- the bank byte of direct-page, stack and PC-relative results;
- the exact fetch address;
- that bank_carry occurs only after an indexed request;
- that an error result is always zero;
- that the flags stay quiet when no result is valid.

Only the scenarios can show the exact sums at the wrap points:
- a direct-page base near 0xFFFF;
- a stack pointer at 0xFFFF;
- a negative PC offset crossing zero;
- indexing from bank 0xFF.

They also show that the bank increments while the low half wraps.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int EA_LOW_W  = 16;
    localparam int EA_BANK_W = 8;
    localparam int EA_OFF_W  = 8;
    localparam int EA_MODE_W = 4;
    localparam int EA_ADDR_W = EA_BANK_W + EA_LOW_W;

    typedef logic [EA_LOW_W-1:0]  ea_low_t;
    typedef logic [EA_BANK_W-1:0] ea_bank_t;
    typedef logic [EA_ADDR_W-1:0] ea_addr_t;
    typedef logic [EA_OFF_W-1:0]  ea_off_t;

    typedef enum logic [EA_MODE_W-1:0] {
        M_DIRECT = 4'd0,
        M_STACK  = 4'd1,
        M_ABS    = 4'd2,
        M_ABS_IX = 4'd3,
        M_LONG   = 4'd4,
        M_FETCH  = 4'd5,
        M_PCREL  = 4'd6,
        M_VECTOR = 4'd7
    } ea_mode_e;

    typedef struct packed {
        ea_addr_t addr;
        logic     carry;
        logic     bad;
    } ea_res_t;

    localparam ea_bank_t BANK_ZERO = '0;

    function automatic ea_addr_t join_bank(ea_bank_t b, ea_low_t l);
        return {b, l};
    endfunction

    function automatic ea_low_t widen_off(ea_off_t o);
        return {{(EA_LOW_W-EA_OFF_W){1'b0}}, o};
    endfunction

endpackage

// File: rtl/ea_index_add.sv
module ea_index_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    assign {cout, sum} = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/ea_mode_mux.sv
module ea_mode_mux
    import ea_pkg::*;
(
    input  logic [EA_MODE_W-1:0] mode,
    input  ea_low_t              operand16,
    input  ea_off_t              offset8,
    input  ea_addr_t             long_operand,
    input  ea_low_t              index,
    input  ea_low_t              dp_base,
    input  ea_low_t              stack_ptr,
    input  ea_bank_t             data_bank,
    input  ea_bank_t             prog_bank,
    input  ea_low_t              prog_ctr,
    output ea_res_t              res
);
    ea_low_t  base_sel;
    ea_low_t  base_sum;
    ea_low_t  rel_sum;
    ea_low_t  ix_sum;
    logic     ix_cout;
    ea_bank_t ix_bank;

    // Direct page and stack share one wrapping adder; the base is picked by mode.
    assign base_sel = (mode == M_STACK) ? stack_ptr : dp_base;
    assign base_sum = base_sel + widen_off(offset8);
    assign rel_sum  = prog_ctr + operand16;

    ea_index_add #(.W(EA_LOW_W)) u_ix_add (
        .a   (operand16),
        .b   (index),
        .sum (ix_sum),
        .cout(ix_cout)
    );

    assign ix_bank = data_bank + {{(EA_BANK_W-1){1'b0}}, ix_cout};

    always_comb begin
        res = '0;
        case (mode)
            M_DIRECT, M_STACK: res.addr = join_bank(BANK_ZERO, base_sum);
            M_ABS:             res.addr = join_bank(data_bank, operand16);
            M_ABS_IX: begin
                res.addr  = join_bank(ix_bank, ix_sum);
                res.carry = ix_cout;
            end
            M_LONG:            res.addr = long_operand;
            M_FETCH:           res.addr = join_bank(prog_bank, prog_ctr);
            M_PCREL:           res.addr = join_bank(prog_bank, rel_sum);
            M_VECTOR:          res.addr = join_bank(BANK_ZERO, operand16);
            default:           res.bad  = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
    import ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [3:0]  mode,
    input  logic [15:0] operand16,
    input  logic [7:0]  offset8,
    input  logic [23:0] long_operand,
    input  logic [15:0] index,
    input  logic [15:0] dp_base,
    input  logic [15:0] stack_ptr,
    input  logic [7:0]  data_bank,
    input  logic [7:0]  prog_bank,
    input  logic [15:0] prog_ctr,
    output logic        out_valid,
    output logic [23:0] addr,
    output logic        bank_carry,
    output logic        bad_mode
);
    ea_res_t res_d;
    ea_res_t res_q;
    logic    valid_q;

    ea_mode_mux u_mux (
        .mode        (mode),
        .operand16   (operand16),
        .offset8     (offset8),
        .long_operand(long_operand),
        .index       (index),
        .dp_base     (dp_base),
        .stack_ptr   (stack_ptr),
        .data_bank   (data_bank),
        .prog_bank   (prog_bank),
        .prog_ctr    (prog_ctr),
        .res         (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) res_q <= res_d;
            else          res_q <= '{addr: res_q.addr, carry: 1'b0, bad: 1'b0};
        end
    end

    assign out_valid  = valid_q;
    assign addr       = res_q.addr;
    assign bank_carry = res_q.carry;
    assign bad_mode   = res_q.bad;

    AST_DP_BANK0: assert property (@(posedge clk) disable iff (rst)
        out_valid && ($past(mode) == M_DIRECT) |-> addr[23:16] == 8'h00); // R1
    AST_STACK_BANK0: assert property (@(posedge clk) disable iff (rst)
        out_valid && ($past(mode) == M_STACK) |-> addr[23:16] == 8'h00); // R2
    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
        out_valid && ($past(mode) == M_FETCH) |-> addr == {$past(prog_bank), $past(prog_ctr)}); // R4
    AST_PCREL_BANK: assert property (@(posedge clk) disable iff (rst)
        out_valid && ($past(mode) == M_PCREL) |-> addr[23:16] == $past(prog_bank)); // R7
    AST_CARRY_IX_ONLY: assert property (@(posedge clk) disable iff (rst)
        out_valid && bank_carry |-> $past(mode) == M_ABS_IX); // R9
    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        bad_mode |-> addr == 24'h000000 && !bank_carry); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !bank_carry && !bad_mode); // R11
endmodule

// File: tb/ea_addr_gen_test.sv
`timescale 1ns/1ps
module ea_addr_gen_test;
    typedef struct {
        string       tag;
        logic [23:0] addr;
        logic        carry;
        logic        bad;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] operand16 = '0, index = '0, dp_base = '0, stack_ptr = '0, prog_ctr = '0;
    logic [7:0]  offset8 = '0, data_bank = '0, prog_bank = '0;
    logic [23:0] long_operand = '0;
    logic        out_valid, bank_carry, bad_mode;
    logic [23:0] addr;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    ea_addr_gen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .operand16(operand16), .offset8(offset8), .long_operand(long_operand),
        .index(index), .dp_base(dp_base), .stack_ptr(stack_ptr),
        .data_bank(data_bank), .prog_bank(prog_bank), .prog_ctr(prog_ctr),
        .out_valid(out_valid), .addr(addr), .bank_carry(bank_carry), .bad_mode(bad_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input string tag, input logic [3:0] m, input logic [15:0] op,
                        input logic [7:0] o8, input logic [23:0] lg, input logic [15:0] ix,
                        input logic [15:0] dpr, input logic [15:0] sp, input logic [7:0] db,
                        input logic [7:0] pb, input logic [15:0] pcv);
        exp_t e;
        logic [16:0] s17;
        @(negedge clk);
        in_valid = 1'b1; mode = m; operand16 = op; offset8 = o8; long_operand = lg;
        index = ix; dp_base = dpr; stack_ptr = sp; data_bank = db; prog_bank = pb; prog_ctr = pcv;
        e.tag = tag; e.addr = '0; e.carry = 1'b0; e.bad = 1'b0;
        s17 = {1'b0, op} + {1'b0, ix};
        case (m)
            4'd0: e.addr = {8'h00, 16'(dpr + {8'h00, o8})};
            4'd1: e.addr = {8'h00, 16'(sp + {8'h00, o8})};
            4'd2: e.addr = {db, op};
            4'd3: begin e.addr = 24'({db, op} + {8'h00, ix}); e.carry = s17[16]; end
            4'd4: e.addr = lg;
            4'd5: e.addr = {pb, pcv};
            4'd6: e.addr = {pb, 16'(pcv + op)};
            4'd7: e.addr = {8'h00, op};
            default: e.bad = 1'b1;
        endcase
        sb.push_back(e);
    endtask

    // Monitor: pops the scoreboard whenever a result is valid.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check("R11 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " addr"}, {8'h0, addr}, {8'h0, e.addr});
                check({"R9 carry ", e.tag}, {31'd0, bank_carry}, {31'd0, e.carry});
                check({"R10 bad ", e.tag}, {31'd0, bad_mode}, {31'd0, e.bad});
            end
        end
    end

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        check("R11 reset valid", {31'd0, out_valid}, 32'd0);
        check("R11 reset addr", {8'h0, addr}, 32'd0);
        check("R11 reset flags", {30'd0, bank_carry, bad_mode}, 32'd0);

        send("R1 dp plain",      4'd0, 16'h0, 8'h10, 24'h0, 16'h0, 16'h1234, 16'h0, 8'h7E, 8'h01, 16'h0);
        send("R1 dp wrap",       4'd0, 16'h0, 8'h20, 24'h0, 16'h0, 16'hFFF0, 16'h0, 8'h7E, 8'h01, 16'h0);
        send("R2 stack",         4'd1, 16'h0, 8'h05, 24'h0, 16'h0, 16'h0, 16'h01FF, 8'h33, 8'h02, 16'h0);
        send("R2 stack wrap",    4'd1, 16'h0, 8'h01, 24'h0, 16'h0, 16'h0, 16'hFFFF, 8'h33, 8'h02, 16'h0);
        send("R3 absolute",      4'd2, 16'h3456, 8'h0, 24'h0, 16'h0, 16'h0, 16'h0, 8'h12, 8'h05, 16'h0);
        send("R6 indexed carry", 4'd3, 16'hFFF0, 8'h0, 24'h0, 16'h0020, 16'h0, 16'h0, 8'h12, 8'h05, 16'h0);
        send("R6 indexed plain", 4'd3, 16'h1000, 8'h0, 24'h0, 16'h0234, 16'h0, 16'h0, 8'h12, 8'h05, 16'h0);
        send("R6 indexed bankFF",4'd3, 16'h8000, 8'h0, 24'h0, 16'h8001, 16'h0, 16'h0, 8'hFF, 8'h05, 16'h0);
        send("R5 long",          4'd4, 16'h1111, 8'h0, 24'hABCDEF, 16'h0, 16'h0, 16'h0, 8'h12, 8'h05, 16'h0);
        send("R4 fetch",         4'd5, 16'h0, 8'h0, 24'h0, 16'h0, 16'h0, 16'h0, 8'h12, 8'h3C, 16'hC0DE);
        send("R7 pcrel fwd",     4'd6, 16'h7FFF, 8'h0, 24'h0, 16'h0, 16'h0, 16'h0, 8'h12, 8'h05, 16'h8000);
        send("R7 pcrel wrap",    4'd6, 16'h0004, 8'h0, 24'h0, 16'h0, 16'h0, 16'h0, 8'h12, 8'h05, 16'hFFFE);
        send("R7 pcrel neg",     4'd6, 16'hFFFE, 8'h0, 24'h0, 16'h0, 16'h0, 16'h0, 8'h12, 8'h05, 16'h0001);
        send("R8 vector",        4'd7, 16'hFFFC, 8'h0, 24'h0, 16'h0, 16'h0, 16'h0, 8'h12, 8'h05, 16'h0);
        send("R10 bad 9",        4'd9, 16'h1234, 8'h5, 24'h123456, 16'hFFFF, 16'h0, 16'h0, 8'h12, 8'h05, 16'h0);
        send("R10 bad 15",       4'd15, 16'hFFFF, 8'h5, 24'h123456, 16'hFFFF, 16'h0, 16'h0, 8'h12, 8'h05, 16'h0);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11 idle valid", {31'd0, out_valid}, 32'd0);
        check("R11 idle flags", {30'd0, bank_carry, bad_mode}, 32'd0);
        check("R11 queue drained", sb.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule